// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Address-Space Matching

This block is a fully associative translation buffer whose contents are written entirely by software. Each slot holds a virtual page-pair number, a variable page mask, an address-space identifier, a global flag, and two physical frames (one for the even page, one for the odd page of the pair). Each frame has its own 3-bit cache attribute and its own dirty and valid bits. A lookup takes a 4 KiB virtual page number and the current address-space identifier. It returns a hit flag, the slot index, and the frame and attributes of the page that was addressed. The same lookup serves as the probe operation.

Software fills slots through an indexed write port and empties the whole table with a one-cycle flush. It reads slots back through a port that packs each slot into the word layouts used by the surrounding control logic. A next-location pointer gives software a replacement slot and steps only when asked. A lookup also marks the access uncached and strictly ordered when the virtual address falls in the uncached segment. Lookup and readback results are registered and appear one clock after the request. Page-table walking and fault raising are left to the logic around the block.

Top module: `soft_tlb`

## Requirements
- R1: A slot matches when the upper VPN bits (lookup VPN without bit 0) equal the stored page-pair number on every bit where the slot's mask is 0. Bits where the mask is 1 are not compared.
- R2: When a slot's global flag is 1, the identifier compare is skipped. Otherwise the lookup identifier must equal the stored identifier for the slot to match.
- R3: A slot takes part in matching only while at least one of its two page valid bits is 1. A slot that matches through one valid page still hits when the other page is addressed, and reports that page's valid bit as 0.
- R4: When more than one slot matches, the lowest-numbered slot is reported.
- R5: On a miss, the hit output is 0, the index output is all ones (5'h1F with default parameters), and the frame and attribute outputs are 0. On a hit, the index is below ENTRIES.
- R6: The page is selected by the lookup VPN bit just above the masked bits. That bit is VPN bit k, where k is the number of 1s in the (contiguous, low-aligned) mask. A value of 0 returns the even frame with its cache, dirty and valid bits, and 1 returns the odd frame with its bits.
- R7: Lookup results are registered. They appear one clock after a cycle with lk_en high and hold while lk_en is low. A lookup in the same cycle as a write sees the table as it was before that write.
- R8: A write whose index is ENTRIES or above changes nothing.
- R9: Readback, one clock after rd_en:
  - each low word is {pfn, cattr[2:0], dirty, valid, global}, with the frame starting at bit 6;
  - the high word is the page-pair number shifted left by 11, with the identifier in the low bits;
  - the mask word is the mask shifted left by 11;
  - an index beyond the table reads as zero.
- R10: A flush clears every slot and sets the next-location pointer to 0. A flush takes priority over a write in the same cycle.
- R11: The next-location pointer steps by one, wrapping from ENTRIES-1 to 0, only in a cycle where rd_en and rd_advance are high and the slot being read is the one the pointer names. In every other cycle it holds.
- R12: lk_uncached is registered with the lookup. It is 1 exactly when {lk_vpn, 12'b0} AND 32'hA000_0000 equals 32'hA000_0000, whether or not the lookup hits.
- R13: After reset, every slot is empty, the pointer is 0, lk_hit is 0, lk_idx is all ones, and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Start a lookup this cycle |
| lk_vpn | input | VPN_W | 4 KiB virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_hit | output | 1 | Registered hit flag |
| lk_idx | output | IDX_W+1 | Matching slot, all ones on a miss |
| lk_pfn | output | PFN_W | Frame of the selected page |
| lk_cattr | output | 3 | Cache attribute of the selected page |
| lk_dirty | output | 1 | Dirty bit of the selected page |
| lk_pvalid | output | 1 | Valid bit of the selected page |
| lk_uncached | output | 1 | Access lies in the uncached, strictly ordered segment |
| wr_en | input | 1 | Write one slot |
| wr_idx | input | IDX_W | Slot to write |
| wr_vpn2 | input | VPN_W-1 | Page-pair number |
| wr_mask | input | VPN_W-1 | Page mask, 1 = bit not compared |
| wr_asid | input | ASID_W | Identifier |
| wr_g | input | 1 | Global flag |
| wr_pfn0 | input | PFN_W | Even-page frame |
| wr_cattr0 | input | 3 | Even-page cache attribute |
| wr_dirty0 | input | 1 | Even-page dirty bit |
| wr_valid0 | input | 1 | Even-page valid bit |
| wr_pfn1 | input | PFN_W | Odd-page frame |
| wr_cattr1 | input | 3 | Odd-page cache attribute |
| wr_dirty1 | input | 1 | Odd-page dirty bit |
| wr_valid1 | input | 1 | Odd-page valid bit |
| flush | input | 1 | Clear every slot and the pointer |
| rd_en | input | 1 | Read one slot back |
| rd_idx | input | IDX_W | Slot to read when rd_from_next is 0 |
| rd_from_next | input | 1 | Read the slot the pointer names |
| rd_advance | input | 1 | Step the pointer if the read slot is the pointed one |
| rd_lo0 | output | PFN_W+6 | Even-page low word |
| rd_lo1 | output | PFN_W+6 | Odd-page low word |
| rd_hi | output | VPN_W+10 | Page-pair number and identifier word |
| rd_mask | output | VPN_W+10 | Mask word |
| next_idx | output | IDX_W | Next-location pointer |

## Verification
The hardest cases to reach from the ports are those where the answer depends on slots that are not reported. Examples are two live slots claiming the same page, a slot kept alive only by its odd valid bit, and a wide mask that moves the page-select bit. The bench builds a fixed table in which these overlaps exist on purpose, then walks a vector list whose pages each land on one of them. Two timing collisions can only be reached by driving two operations in the same cycle: a lookup racing a write to the slot it would hit, and a flush racing a write. The pointer wrap needs a full lap of matching reads, which the bench drives as a counted loop.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int CATTR_W      = 3;
  localparam int LO_FLAG_BITS = CATTR_W + 3;  // cattr, dirty, valid, global
  localparam int HI_SHIFT     = 11;

  typedef struct packed {
    logic [CATTR_W-1:0] cattr;
    logic               dirty;
    logic               valid;
  } page_attr_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store import tlb_pkg::*; #(
  parameter int ENTRIES = 12,
  parameter int IDX_W   = 4,
  parameter int VPN2_W  = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [VPN2_W-1:0] wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_g,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  page_attr_t        wr_attr0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  page_attr_t        wr_attr1,
  output logic [VPN2_W-1:0] e_vpn2  [ENTRIES],
  output logic [VPN2_W-1:0] e_mask  [ENTRIES],
  output logic [ASID_W-1:0] e_asid  [ENTRIES],
  output logic [PFN_W-1:0]  e_pfn0  [ENTRIES],
  output logic [PFN_W-1:0]  e_pfn1  [ENTRIES],
  output page_attr_t        e_attr0 [ENTRIES],
  output page_attr_t        e_attr1 [ENTRIES],
  output logic [ENTRIES-1:0] e_g,
  output logic [ENTRIES-1:0] e_live
);
  logic wr_in_range;
  assign wr_in_range = int'(wr_idx) < ENTRIES;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn2[i]  <= '0;
        e_mask[i]  <= '0;
        e_asid[i]  <= '0;
        e_pfn0[i]  <= '0;
        e_pfn1[i]  <= '0;
        e_attr0[i] <= '0;
        e_attr1[i] <= '0;
        e_g[i]     <= 1'b0;
      end
    end else if (wr_en && wr_in_range) begin
      e_vpn2[wr_idx]  <= wr_vpn2;
      e_mask[wr_idx]  <= wr_mask;
      e_asid[wr_idx]  <= wr_asid;
      e_pfn0[wr_idx]  <= wr_pfn0;
      e_pfn1[wr_idx]  <= wr_pfn1;
      e_attr0[wr_idx] <= wr_attr0;
      e_attr1[wr_idx] <= wr_attr1;
      e_g[wr_idx]     <= wr_g;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign e_live[i] = e_attr0[i].valid | e_attr1[i].valid;

    AST_OOR_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !flush && !wr_in_range) |=>
        ($stable(e_vpn2[i]) && $stable(e_mask[i]) && $stable(e_asid[i]) &&
         $stable(e_pfn0[i]) && $stable(e_pfn1[i]) && $stable(e_attr0[i]) &&
         $stable(e_attr1[i]) && $stable(e_g[i]))); // R8
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (e_live == '0 && e_g == '0)); // R10
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 12,
  parameter int VPN_W   = 20,
  parameter int VPN2_W  = 19,
  parameter int ASID_W  = 8
) (
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [VPN2_W-1:0]  e_vpn2 [ENTRIES],
  input  logic [VPN2_W-1:0]  e_mask [ENTRIES],
  input  logic [ASID_W-1:0]  e_asid [ENTRIES],
  input  logic [ENTRIES-1:0] e_g,
  input  logic [ENTRIES-1:0] e_live,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] odd_vec
);
  logic [VPN2_W-1:0] lk_vpn2;
  assign lk_vpn2 = lk_vpn[VPN_W-1:1];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VPN2_W-1:0] diff;
    logic              asid_ok;
    logic              sel;

    assign diff    = (lk_vpn2 ^ e_vpn2[i]) & ~e_mask[i];
    assign asid_ok = e_g[i] || (lk_asid == e_asid[i]);
    assign hit_vec[i] = e_live[i] && (diff == '0) && asid_ok;

    // page-select bit sits just above the masked span
    always_comb begin
      sel = lk_vpn[0];
      for (int b = 0; b < VPN2_W; b++) begin
        if (e_mask[i][b]) sel = lk_vpn[b+1];
      end
    end
    assign odd_vec[i] = sel;
  end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int N     = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found    = 1'b1;
        idx      = IDX_W'(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R4
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
    found |-> (((grant - N'(1)) & req) == '0 && (grant & req) == grant)); // R4
endmodule

// File: rtl/tlb_next_ptr.sv
module tlb_next_ptr #(
  parameter int ENTRIES = 12,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             rd_en,
  input  logic             rd_advance,
  input  logic [IDX_W-1:0] rd_idx_eff,
  output logic [IDX_W-1:0] nlu
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic step;
  assign step = rd_en && rd_advance && (rd_idx_eff == nlu);

  always_ff @(posedge clk) begin
    if (rst || flush)  nlu <= '0;
    else if (step)     nlu <= (nlu == LAST) ? '0 : nlu + IDX_W'(1);
  end

  AST_NLU_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(nlu) < ENTRIES); // R11
  AST_NLU_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!flush && !(rd_en && rd_advance && rd_idx_eff == nlu)) |=> $stable(nlu)); // R11
  AST_NLU_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!flush && rd_en && rd_advance && rd_idx_eff == nlu && nlu == LAST) |=> (nlu == '0)); // R11
  AST_FLUSH_PTR: assert property (@(posedge clk) disable iff (rst)
    flush |=> (nlu == '0)); // R10
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb import tlb_pkg::*; #(
  parameter int          ENTRIES     = 12,
  parameter int          VPN_W       = 20,
  parameter int          ASID_W      = 8,
  parameter int          PFN_W       = 20,
  parameter int          PAGE_SHIFT  = 12,
  parameter logic [63:0] UNC_PATTERN = 64'hA000_0000,
  localparam int         IDX_W       = $clog2(ENTRIES),
  localparam int         PIDX_W      = IDX_W + 1,
  localparam int         VPN2_W      = VPN_W - 1,
  localparam int         LO_W        = PFN_W + LO_FLAG_BITS,
  localparam int         HI_W        = VPN2_W + HI_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_en,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic               lk_hit,
  output logic [PIDX_W-1:0]  lk_idx,
  output logic [PFN_W-1:0]   lk_pfn,
  output logic [CATTR_W-1:0] lk_cattr,
  output logic               lk_dirty,
  output logic               lk_pvalid,
  output logic               lk_uncached,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN2_W-1:0]  wr_vpn2,
  input  logic [VPN2_W-1:0]  wr_mask,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic               wr_g,
  input  logic [PFN_W-1:0]   wr_pfn0,
  input  logic [CATTR_W-1:0] wr_cattr0,
  input  logic               wr_dirty0,
  input  logic               wr_valid0,
  input  logic [PFN_W-1:0]   wr_pfn1,
  input  logic [CATTR_W-1:0] wr_cattr1,
  input  logic               wr_dirty1,
  input  logic               wr_valid1,
  input  logic               flush,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic               rd_from_next,
  input  logic               rd_advance,
  output logic [LO_W-1:0]    rd_lo0,
  output logic [LO_W-1:0]    rd_lo1,
  output logic [HI_W-1:0]    rd_hi,
  output logic [HI_W-1:0]    rd_mask,
  output logic [IDX_W-1:0]   next_idx
);
  localparam int               VA_W     = VPN_W + PAGE_SHIFT;
  localparam logic [VA_W-1:0]  UNC_MASK = VA_W'(UNC_PATTERN);

  // ---------------- storage ----------------
  logic [VPN2_W-1:0]  e_vpn2  [ENTRIES];
  logic [VPN2_W-1:0]  e_mask  [ENTRIES];
  logic [ASID_W-1:0]  e_asid  [ENTRIES];
  logic [PFN_W-1:0]   e_pfn0  [ENTRIES];
  logic [PFN_W-1:0]   e_pfn1  [ENTRIES];
  page_attr_t         e_attr0 [ENTRIES];
  page_attr_t         e_attr1 [ENTRIES];
  logic [ENTRIES-1:0] e_g;
  logic [ENTRIES-1:0] e_live;
  page_attr_t         wr_attr0, wr_attr1;

  assign wr_attr0 = '{cattr: wr_cattr0, dirty: wr_dirty0, valid: wr_valid0};
  assign wr_attr1 = '{cattr: wr_cattr1, dirty: wr_dirty1, valid: wr_valid1};

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN2_W(VPN2_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_store (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn2(wr_vpn2), .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_g(wr_g),
    .wr_pfn0(wr_pfn0), .wr_attr0(wr_attr0), .wr_pfn1(wr_pfn1), .wr_attr1(wr_attr1),
    .e_vpn2(e_vpn2), .e_mask(e_mask), .e_asid(e_asid), .e_pfn0(e_pfn0),
    .e_pfn1(e_pfn1), .e_attr0(e_attr0), .e_attr1(e_attr1), .e_g(e_g), .e_live(e_live)
  );

  // ---------------- lookup path ----------------
  logic [ENTRIES-1:0] hit_vec, odd_vec, grant;
  logic               found;
  logic [IDX_W-1:0]   win_idx;

  tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .VPN2_W(VPN2_W), .ASID_W(ASID_W)
  ) u_match (
    .lk_vpn(lk_vpn), .lk_asid(lk_asid), .e_vpn2(e_vpn2), .e_mask(e_mask),
    .e_asid(e_asid), .e_g(e_g), .e_live(e_live), .hit_vec(hit_vec), .odd_vec(odd_vec)
  );

  tlb_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) u_first (
    .clk(clk), .rst(rst), .req(hit_vec), .found(found), .idx(win_idx), .grant(grant)
  );

  logic [PFN_W-1:0] sel_pfn;
  page_attr_t       sel_attr;

  always_comb begin
    sel_pfn  = '0;
    sel_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant[i]) begin
        sel_pfn  = odd_vec[i] ? e_pfn1[i]  : e_pfn0[i];
        sel_attr = odd_vec[i] ? e_attr1[i] : e_attr0[i];
      end
    end
  end

  logic [VA_W-1:0] lk_va;
  logic            unc_now;
  assign lk_va   = {lk_vpn, {PAGE_SHIFT{1'b0}}};
  assign unc_now = (lk_va & UNC_MASK) == UNC_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit      <= 1'b0;
      lk_idx      <= '1;
      lk_pfn      <= '0;
      lk_cattr    <= '0;
      lk_dirty    <= 1'b0;
      lk_pvalid   <= 1'b0;
      lk_uncached <= 1'b0;
    end else if (lk_en) begin
      lk_hit      <= found;
      lk_idx      <= found ? {1'b0, win_idx} : '1;
      lk_pfn      <= sel_pfn;
      lk_cattr    <= sel_attr.cattr;
      lk_dirty    <= sel_attr.dirty;
      lk_pvalid   <= sel_attr.valid;
      lk_uncached <= unc_now;
    end
  end

  // ---------------- readback and replacement pointer ----------------
  logic [IDX_W-1:0] rd_idx_eff;
  assign rd_idx_eff = rd_from_next ? next_idx : rd_idx;

  tlb_next_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_next (
    .clk(clk), .rst(rst), .flush(flush), .rd_en(rd_en), .rd_advance(rd_advance),
    .rd_idx_eff(rd_idx_eff), .nlu(next_idx)
  );

  logic [LO_W-1:0] rb_lo0, rb_lo1;
  logic [HI_W-1:0] rb_hi, rb_mask;

  always_comb begin
    rb_lo0  = '0;
    rb_lo1  = '0;
    rb_hi   = '0;
    rb_mask = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_idx_eff == IDX_W'(i)) begin
        rb_lo0  = {e_pfn0[i], e_attr0[i].cattr, e_attr0[i].dirty, e_attr0[i].valid, e_g[i]};
        rb_lo1  = {e_pfn1[i], e_attr1[i].cattr, e_attr1[i].dirty, e_attr1[i].valid, e_g[i]};
        rb_hi   = {e_vpn2[i], {(HI_SHIFT-ASID_W){1'b0}}, e_asid[i]};
        rb_mask = {e_mask[i], {HI_SHIFT{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_lo0  <= '0;
      rd_lo1  <= '0;
      rd_hi   <= '0;
      rd_mask <= '0;
    end else if (rd_en) begin
      rd_lo0  <= rb_lo0;
      rd_lo1  <= rb_lo1;
      rd_hi   <= rb_hi;
      rd_mask <= rb_mask;
    end
  end

  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_idx == '1 && lk_pfn == '0 && !lk_pvalid)); // R5
  AST_HIT_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (int'(lk_idx) < ENTRIES)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !lk_en |=> ($stable(lk_hit) && $stable(lk_idx) && $stable(lk_pfn) &&
                $stable(lk_uncached))); // R7
  AST_LOOKUP_HIT_SET: assert property (@(posedge clk) disable iff (rst)
    (lk_en && hit_vec != '0) |=> lk_hit); // R7
endmodule

// File: tb/tb_soft_tlb.sv
module tb_soft_tlb;
  localparam int ENTRIES = 12;
  localparam int IDX_W   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_en = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit;
  logic [4:0]  lk_idx;
  logic [19:0] lk_pfn;
  logic [2:0]  lk_cattr;
  logic        lk_dirty, lk_pvalid, lk_uncached;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn2 = '0, wr_mask = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_g = 1'b0;
  logic [19:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic [2:0]  wr_cattr0 = '0, wr_cattr1 = '0;
  logic        wr_dirty0 = 1'b0, wr_valid0 = 1'b0, wr_dirty1 = 1'b0, wr_valid1 = 1'b0;
  logic        flush = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic        rd_from_next = 1'b0, rd_advance = 1'b0;
  logic [25:0] rd_lo0, rd_lo1;
  logic [29:0] rd_hi, rd_mask;
  logic [3:0]  next_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  soft_tlb #(.ENTRIES(ENTRIES)) dut (
    .clk(clk), .rst(rst), .lk_en(lk_en), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pfn(lk_pfn), .lk_cattr(lk_cattr),
    .lk_dirty(lk_dirty), .lk_pvalid(lk_pvalid), .lk_uncached(lk_uncached),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_g(wr_g), .wr_pfn0(wr_pfn0), .wr_cattr0(wr_cattr0),
    .wr_dirty0(wr_dirty0), .wr_valid0(wr_valid0), .wr_pfn1(wr_pfn1),
    .wr_cattr1(wr_cattr1), .wr_dirty1(wr_dirty1), .wr_valid1(wr_valid1),
    .flush(flush), .rd_en(rd_en), .rd_idx(rd_idx), .rd_from_next(rd_from_next),
    .rd_advance(rd_advance), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1), .rd_hi(rd_hi),
    .rd_mask(rd_mask), .next_idx(next_idx)
  );

  // {vpn[19:0], asid[7:0], hit, idx[4:0], pfn[19:0], cattr[2:0], dirty, pvalid, uncached}
  localparam logic [59:0] LK_VEC [15] = '{
    {20'h00020, 8'h05, 1'b1, 5'd0,  20'h00100, 3'd3, 1'b1, 1'b1, 1'b0},
    {20'h00021, 8'h05, 1'b1, 5'd0,  20'h00101, 3'd2, 1'b0, 1'b1, 1'b0},
    {20'h00020, 8'h06, 1'b0, 5'h1F, 20'h00000, 3'd0, 1'b0, 1'b0, 1'b0},
    {20'h00040, 8'h33, 1'b1, 5'd1,  20'h00200, 3'd1, 1'b0, 1'b1, 1'b0},
    {20'h00041, 8'h33, 1'b1, 5'd1,  20'h00201, 3'd0, 1'b0, 1'b0, 1'b0},
    {20'h00205, 8'h05, 1'b1, 5'd2,  20'h00301, 3'd5, 1'b1, 1'b1, 1'b0},
    {20'h00203, 8'h05, 1'b1, 5'd2,  20'h00300, 3'd4, 1'b0, 1'b1, 1'b0},
    {20'h00208, 8'h05, 1'b0, 5'h1F, 20'h00000, 3'd0, 1'b0, 1'b0, 1'b0},
    {20'h00060, 8'h00, 1'b0, 5'h1F, 20'h00000, 3'd0, 1'b0, 1'b0, 1'b0},
    {20'h00081, 8'h07, 1'b1, 5'd5,  20'h00501, 3'd6, 1'b1, 1'b1, 1'b0},
    {20'h00080, 8'h07, 1'b1, 5'd5,  20'h00500, 3'd7, 1'b1, 1'b0, 1'b0},
    {20'hA0000, 8'h44, 1'b1, 5'd6,  20'h00600, 3'd2, 1'b0, 1'b1, 1'b1},
    {20'hE0001, 8'h01, 1'b0, 5'h1F, 20'h00000, 3'd0, 1'b0, 1'b0, 1'b1},
    {20'h80000, 8'h01, 1'b0, 5'h1F, 20'h00000, 3'd0, 1'b0, 1'b0, 1'b0},
    {20'h20000, 8'h01, 1'b0, 5'h1F, 20'h00000, 3'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic set_entry(input logic [3:0] idx, input logic [18:0] vpn2,
                           input logic [18:0] mask, input logic [7:0] asid, input logic g,
                           input logic [19:0] p0, input logic [2:0] c0, input logic d0, input logic v0,
                           input logic [19:0] p1, input logic [2:0] c1, input logic d1, input logic v1);
    wr_idx = idx; wr_vpn2 = vpn2; wr_mask = mask; wr_asid = asid; wr_g = g;
    wr_pfn0 = p0; wr_cattr0 = c0; wr_dirty0 = d0; wr_valid0 = v0;
    wr_pfn1 = p1; wr_cattr1 = c1; wr_dirty1 = d1; wr_valid1 = v1;
  endtask

  task automatic do_write(input logic [3:0] idx, input logic [18:0] vpn2,
                          input logic [18:0] mask, input logic [7:0] asid, input logic g,
                          input logic [19:0] p0, input logic [2:0] c0, input logic d0, input logic v0,
                          input logic [19:0] p1, input logic [2:0] c1, input logic d1, input logic v1);
    @(negedge clk);
    set_entry(idx, vpn2, mask, asid, g, p0, c0, d0, v0, p1, c1, d1, v1);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_lookup(input logic [19:0] vpn, input logic [7:0] asid);
    @(negedge clk);
    lk_en = 1'b1; lk_vpn = vpn; lk_asid = asid;
    @(negedge clk);
    lk_en = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] idx, input logic from_next, input logic adv);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx; rd_from_next = from_next; rd_advance = adv;
    @(negedge clk);
    rd_en = 1'b0; rd_from_next = 1'b0; rd_advance = 1'b0;
  endtask

  function automatic logic [31:0] lk_pack();
    return {lk_hit, lk_idx, lk_pfn, lk_cattr, lk_dirty, lk_pvalid, lk_uncached};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    check("R13", "hit after reset", 64'(lk_hit), 64'd0);
    check("R13", "idx after reset", 64'(lk_idx), 64'h1F);
    check("R13", "pointer after reset", 64'(next_idx), 64'd0);
    check("R13", "readback after reset", 64'({rd_lo0, rd_hi}), 64'd0);

    // fixed table with overlaps on purpose
    do_write(4'd0, 19'h00010, 19'h0, 8'h05, 1'b0, 20'h00100, 3'd3, 1'b1, 1'b1, 20'h00101, 3'd2, 1'b0, 1'b1);
    do_write(4'd1, 19'h00020, 19'h0, 8'h09, 1'b1, 20'h00200, 3'd1, 1'b0, 1'b1, 20'h00201, 3'd0, 1'b0, 1'b0);
    do_write(4'd2, 19'h00100, 19'h3, 8'h05, 1'b0, 20'h00300, 3'd4, 1'b0, 1'b1, 20'h00301, 3'd5, 1'b1, 1'b1);
    do_write(4'd3, 19'h00010, 19'h0, 8'h05, 1'b0, 20'h00400, 3'd1, 1'b0, 1'b1, 20'h00401, 3'd1, 1'b0, 1'b1);
    do_write(4'd4, 19'h00030, 19'h0, 8'h00, 1'b1, 20'h004A0, 3'd0, 1'b0, 1'b0, 20'h004A1, 3'd0, 1'b0, 1'b0);
    do_write(4'd5, 19'h00040, 19'h0, 8'h07, 1'b0, 20'h00500, 3'd7, 1'b1, 1'b0, 20'h00501, 3'd6, 1'b1, 1'b1);
    do_write(4'd6, 19'h50000, 19'h0, 8'h05, 1'b1, 20'h00600, 3'd2, 1'b0, 1'b1, 20'h00601, 3'd2, 1'b0, 1'b1);

    // vector walk: R1/R2/R3/R4/R5/R6/R12
    for (int v = 0; v < 15; v++) begin
      do_lookup(LK_VEC[v][59:40], LK_VEC[v][39:32]);
      check("R1/R2/R3/R4/R5/R6/R12", $sformatf("lookup vector %0d", v),
            64'(lk_pack()), 64'(LK_VEC[v][31:0]));
    end

    // R9 readback formats
    do_read(4'd0, 1'b0, 1'b0);
    check("R9", "slot0 even low word", 64'(rd_lo0), 64'h401E);
    check("R9", "slot0 odd low word", 64'(rd_lo1), 64'h4052);
    check("R9", "slot0 high word", 64'(rd_hi), 64'h8005);
    check("R9", "slot0 mask word", 64'(rd_mask), 64'h0);
    do_read(4'd2, 1'b0, 1'b0);
    check("R9", "slot2 mask word", 64'(rd_mask), 64'h1800);
    check("R9", "slot2 high word", 64'(rd_hi), 64'h80005);
    do_read(4'd1, 1'b0, 1'b0);
    check("R9", "slot1 global low word", 64'(rd_lo0), 64'h800B);
    do_read(4'd14, 1'b0, 1'b0);
    check("R9", "beyond-table read", 64'({rd_lo0, rd_hi}), 64'd0);

    // R8 write beyond table is dropped
    do_write(4'd13, 19'h00700, 19'h0, 8'h00, 1'b1, 20'h00777, 3'd1, 1'b0, 1'b1, 20'h0, 3'd0, 1'b0, 1'b0);
    do_lookup(20'h00E00, 8'h00);
    check("R8", "lookup after dropped write", 64'({lk_hit, lk_idx}), 64'h1F);
    do_read(4'd0, 1'b0, 1'b0);
    check("R8", "slot0 intact after dropped write", 64'(rd_lo0), 64'h401E);

    // R7 lookup racing a write sees old table, then new table, then holds
    @(negedge clk);
    set_entry(4'd7, 19'h00700, 19'h0, 8'h00, 1'b1, 20'h00777, 3'd1, 1'b0, 1'b1, 20'h0, 3'd0, 1'b0, 1'b0);
    wr_en = 1'b1; lk_en = 1'b1; lk_vpn = 20'h00E00; lk_asid = 8'h00;
    @(negedge clk);
    wr_en = 1'b0; lk_en = 1'b0;
    check("R7", "lookup same cycle as write", 64'({lk_hit, lk_idx}), 64'h1F);
    do_lookup(20'h00E00, 8'h00);
    check("R7", "lookup after write", 64'({lk_hit, lk_idx, lk_pfn}), {39'd0, 1'b1, 5'd7, 20'h00777});
    lk_vpn = 20'h00020;
    @(negedge clk);
    @(negedge clk);
    check("R7", "hold with lk_en low", 64'({lk_hit, lk_idx, lk_pfn}), {39'd0, 1'b1, 5'd7, 20'h00777});

    // R11 replacement pointer
    check("R11", "pointer start", 64'(next_idx), 64'd0);
    do_read(4'd0, 1'b1, 1'b1);
    check("R11", "step on pointed read", 64'(next_idx), 64'd1);
    do_read(4'd5, 1'b0, 1'b1);
    check("R11", "no step on other slot", 64'(next_idx), 64'd1);
    @(negedge clk);
    rd_advance = 1'b1;
    @(negedge clk);
    rd_advance = 1'b0;
    check("R11", "no step without read", 64'(next_idx), 64'd1);
    for (int k = 0; k < 10; k++) do_read(4'd0, 1'b1, 1'b1);
    check("R11", "pointer at last slot", 64'(next_idx), 64'd11);
    do_read(4'd0, 1'b1, 1'b1);
    check("R11", "pointer wraps", 64'(next_idx), 64'd0);
    do_read(4'd0, 1'b1, 1'b1);

    // R10 flush beats a same-cycle write
    @(negedge clk);
    set_entry(4'd8, 19'h00800, 19'h0, 8'h00, 1'b1, 20'h00888, 3'd1, 1'b0, 1'b1, 20'h0, 3'd0, 1'b0, 1'b0);
    wr_en = 1'b1; flush = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; flush = 1'b0;
    check("R10", "pointer after flush", 64'(next_idx), 64'd0);
    do_lookup(20'h00020, 8'h05);
    check("R10", "slot0 gone", 64'({lk_hit, lk_idx}), 64'h1F);
    do_lookup(20'h01000, 8'h00);
    check("R10", "racing write dropped", 64'({lk_hit, lk_idx}), 64'h1F);
    do_read(4'd0, 1'b0, 1'b0);
    check("R10", "slot0 readback zero", 64'({rd_lo0, rd_hi}), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule